// File: doc/BRIEF.md
# Clock Enable Generator with Selectable Dividers

This block derives every clock of a small microcontroller from one reference clock, the on-chip RC oscillator, which also clocks the block itself. It produces single-cycle enable pulses in that domain: a high-speed enable, a low-speed enable and its double-rate companion, a CPU system-clock enable and a port output-clock enable. The high-speed enable either fires on every reference cycle or follows an external clock tick. The low-speed pair is made by dividing the reference by 16 and by 8. When a crystal is fitted, the pair instead follows a crystal tick input. In that case the double-rate enable tracks every crystal tick, and the low-speed enable tracks every second one.

Two power-of-two dividers, one for the system clock and one for the output clock, each count high-speed enables and divide by 1, 2, 4 or 8. The system-clock enable comes from a multiplexer that picks either the divided high-speed enable or the low-speed enable. Software programs the dividers and the multiplexer through two small control registers on a write/read register port. A new ratio or a new source never cuts a period short: it is taken over only when the period that is running completes. After reset the system clock runs at the RC rate divided by 8.

Top module: `cgenClockCtrl`

## Requirements
- R1: After reset the system-clock enable is the high-speed enable divided by 8: with the RC source its first pulse is on the 8th reference cycle after reset release, and it repeats every 8 cycles. The status output `sysOnLow` is 0.
- R2: The system divider code selects a period in high-speed enables: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: The output divider uses the same codes, counts the same high-speed enables, and runs independently of the system divider.
- R4: A newly written divider code takes effect only after the divider's current period has ended. The period that is running keeps its old length.
- R5: With the low-speed source set to RC, `lsEn` fires once every 16 reference cycles and `ls2En` fires once every 8 cycles. Every `lsEn` pulse falls on an `ls2En` pulse.
- R6: With the low-speed source set to crystal, `ls2En` follows each `xtalTick`, and `lsEn` fires on every second one. The change of low-speed source happens only at an `lsEn` pulse of the old source, and crystal phase counting restarts there.
- R7: The system-clock source select (0 = divided high-speed, 1 = low-speed) takes effect only at a `sysEn` pulse of the current source. `sysOnLow` reports the source that is in effect.
- R8: With the high-speed source set to external, `hsEn` equals `extTick`, and both dividers count only those ticks. With the RC source, `hsEn` is 1 on every cycle.
- R9: Register 0 holds the system divider code in bits [1:0] and the output divider code in bits [3:2]; its reset value is 4'hF. Register 1 holds the system source select in bit 0, the high-speed source select in bit 1 (1 = external) and the low-speed source select in bit 2 (1 = crystal); its reset value is 0. Bit 3 of register 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (RC oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select (0 or 1) |
| regWdata | input | 4 | Write data |
| regRdata | output | 4 | Read data of the selected register |
| extTick | input | 1 | External high-speed clock tick |
| xtalTick | input | 1 | Crystal tick at the double low-speed rate |
| hsEn | output | 1 | High-speed clock enable |
| lsEn | output | 1 | Low-speed clock enable |
| ls2En | output | 1 | Double-rate low-speed enable |
| sysEn | output | 1 | System clock enable |
| outEn | output | 1 | Output clock enable |
| sysOnLow | output | 1 | System clock currently taken from the low-speed enable |

## Verification
The bound checker watches several relations on every cycle. A divided pulse never appears without a high-speed enable beneath it. Every low-speed pulse coincides with a double-rate pulse. The source status changes only in the cycle after a system pulse. The exact periods, the reset default of divide-by-8, and the deferral of a ratio or source change to the end of the period that is running can only be shown by the bench's scenarios. There, a cycle-accurate scoreboard model is compared against every enable while the registers are rewritten in mid-period.

// File: rtl/cgenPkg.sv
package cgenPkg;
  localparam int DIV_CODE_W = 2;

  typedef logic [DIV_CODE_W-1:0] divCode_t;

  // settings handed from the register side to the counting side
  typedef struct packed {
    logic     hsFromExt;
    logic     lsFromXtal;
    logic     sysFromLow;
    divCode_t sysDiv;
    divCode_t outDiv;
  } cgenCtrl_t;
endpackage

// File: rtl/cgenRegs.sv
module cgenRegs
  import cgenPkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output cgenCtrl_t         ctrl
);
  localparam int DIVS_W = 2 * DIV_CODE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.hsFromExt  <= 1'b0;
      ctrl.lsFromXtal <= 1'b0;
      ctrl.sysFromLow <= 1'b0;
      ctrl.sysDiv     <= '1;
      ctrl.outDiv     <= '1;
    end else if (regWe) begin
      if (!regAddr) begin
        ctrl.sysDiv <= regWdata[DIV_CODE_W-1:0];
        ctrl.outDiv <= regWdata[DIVS_W-1:DIV_CODE_W];
      end else begin
        ctrl.sysFromLow <= regWdata[0];
        ctrl.hsFromExt  <= regWdata[1];
        ctrl.lsFromXtal <= regWdata[2];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (!regAddr) begin
      regRdata[DIVS_W-1:0] = {ctrl.outDiv, ctrl.sysDiv};
    end else begin
      regRdata[2:0] = {ctrl.lsFromXtal, ctrl.hsFromExt, ctrl.sysFromLow};
    end
  end
endmodule

// File: rtl/cgenDivider.sv
module cgenDivider
  import cgenPkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  divCode_t reqDiv,
  output logic     pulse
);
  localparam int CNT_W = (1 << DIV_CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  divCode_t         actDiv;

  always_comb limit = CNT_W'((1 << actDiv) - 1);

  assign pulse = tick && (cnt == limit);

  // a requested ratio is adopted only when the running period closes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      actDiv <= '1;
    end else if (tick) begin
      if (pulse) begin
        cnt    <= '0;
        actDiv <= reqDiv;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cgenDatapath.sv
module cgenDatapath
  import cgenPkg::*;
#(
  parameter int LS_DIV_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      extTick,
  input  logic      xtalTick,
  input  cgenCtrl_t ctrl,
  output logic      hsEn,
  output logic      lsEn,
  output logic      ls2En,
  output logic      sysEn,
  output logic      outEn,
  output logic      sysOnLow
);
  logic [LS_DIV_LOG2-1:0] rcCnt;
  logic rcLs, rcLs2, xtLs;
  logic lsSelXtal, xtPhase;
  logic sysHsPulse;

  assign hsEn = ctrl.hsFromExt ? extTick : 1'b1;

  cgenDivider u_sysDiv (
    .clk(clk), .rst_n(rst_n), .tick(hsEn), .reqDiv(ctrl.sysDiv), .pulse(sysHsPulse)
  );

  cgenDivider u_outDiv (
    .clk(clk), .rst_n(rst_n), .tick(hsEn), .reqDiv(ctrl.outDiv), .pulse(outEn)
  );

  // fallback low-speed pair from the RC reference
  always_ff @(posedge clk) begin
    if (!rst_n) rcCnt <= '0;
    else        rcCnt <= rcCnt + LS_DIV_LOG2'(1);
  end

  assign rcLs  = &rcCnt;
  assign rcLs2 = &rcCnt[LS_DIV_LOG2-2:0];
  assign xtLs  = xtalTick && xtPhase;

  assign lsEn  = lsSelXtal ? xtLs     : rcLs;
  assign ls2En = lsSelXtal ? xtalTick : rcLs2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsSelXtal <= 1'b0;
      xtPhase   <= 1'b0;
    end else if (lsEn && (lsSelXtal != ctrl.lsFromXtal)) begin
      lsSelXtal <= ctrl.lsFromXtal;
      xtPhase   <= 1'b0;
    end else if (xtalTick) begin
      xtPhase <= ~xtPhase;
    end
  end

  assign sysEn = sysOnLow ? lsEn : sysHsPulse;

  always_ff @(posedge clk) begin
    if (!rst_n)     sysOnLow <= 1'b0;
    else if (sysEn) sysOnLow <= ctrl.sysFromLow;
  end
endmodule

// File: rtl/cgenClockCtrl.sv
module cgenClockCtrl
  import cgenPkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int LS_DIV_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              extTick,
  input  logic              xtalTick,
  output logic              hsEn,
  output logic              lsEn,
  output logic              ls2En,
  output logic              sysEn,
  output logic              outEn,
  output logic              sysOnLow
);
  cgenCtrl_t ctrl;

  cgenRegs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctrl(ctrl)
  );

  cgenDatapath #(.LS_DIV_LOG2(LS_DIV_LOG2)) u_path (
    .clk(clk), .rst_n(rst_n), .extTick(extTick), .xtalTick(xtalTick), .ctrl(ctrl),
    .hsEn(hsEn), .lsEn(lsEn), .ls2En(ls2En), .sysEn(sysEn), .outEn(outEn),
    .sysOnLow(sysOnLow)
  );
endmodule

// File: rtl/cgenClockCtrlChk.sv
module cgenClockCtrlChk (
  input logic clk,
  input logic rst_n,
  input logic hsEn,
  input logic lsEn,
  input logic ls2En,
  input logic sysEn,
  input logic outEn,
  input logic sysOnLow
);
  AST_SYS_HS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (sysEn && !sysOnLow) |-> hsEn); // R2
  AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) outEn |-> hsEn); // R3
  AST_LS_ON_LS2: assert property (@(posedge clk) disable iff (!rst_n) lsEn |-> ls2En); // R5
  AST_SRC_SWITCH_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sysOnLow) |-> $past(sysEn)); // R7
endmodule

bind cgenClockCtrl cgenClockCtrlChk u_chk (.*);

// File: tb/test_cgenClockCtrl.sv
module test_cgenClockCtrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWe = 1'b0;
  logic regAddr = 1'b0;
  logic [3:0] regWdata = '0;
  logic [3:0] regRdata;
  logic extTick = 1'b0;
  logic xtalTick = 1'b0;
  logic hsEn, lsEn, ls2En, sysEn, outEn, sysOnLow;

  always #4 clk = ~clk;

  cgenClockCtrl i_cgenClockCtrl (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .extTick(extTick), .xtalTick(xtalTick), .hsEn(hsEn),
    .lsEn(lsEn), .ls2En(ls2En), .sysEn(sysEn), .outEn(outEn), .sysOnLow(sysOnLow)
  );

  typedef struct packed { logic hs, ls, ls2, sys, out, onLow; } expect_t;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  logic monOn = 1'b0;
  logic extOn = 1'b0;
  logic xtalOn = 1'b0;
  int tickCyc = 0;
  expect_t sbQ[$];

  // independent model: down-counters for dividers, cycle count for RC pair
  int mCyc, mSysLeft, mOutLeft;
  int mSysReq, mOutReq;
  logic mSysLow, mHsExt, mLsX, mLsSel, mSysSel, mXtPar;

  function automatic expect_t calc();
    expect_t e;
    logic lsRc, ls2Rc;
    e.hs  = mHsExt ? extTick : 1'b1;
    lsRc  = (mCyc % 16) == 15;
    ls2Rc = (mCyc % 8) == 7;
    e.ls  = mLsSel ? (xtalTick && mXtPar) : lsRc;
    e.ls2 = mLsSel ? xtalTick : ls2Rc;
    e.out = e.hs && (mOutLeft == 1);
    e.sys = mSysSel ? e.ls : (e.hs && (mSysLeft == 1));
    e.onLow = mSysSel;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCyc = 0; mSysLeft = 8; mOutLeft = 8; mSysReq = 3; mOutReq = 3;
      mSysLow = 0; mHsExt = 0; mLsX = 0; mLsSel = 0; mSysSel = 0; mXtPar = 0;
    end else begin
      expect_t e;
      e = calc();
      if (e.hs) begin
        mSysLeft = (mSysLeft == 1) ? (1 << mSysReq) : mSysLeft - 1;
        mOutLeft = (mOutLeft == 1) ? (1 << mOutReq) : mOutLeft - 1;
      end
      if (e.ls && (mLsSel != mLsX)) begin
        mLsSel = mLsX; mXtPar = 0;
      end else if (xtalTick) begin
        mXtPar = !mXtPar;
      end
      if (e.sys) mSysSel = mSysLow;
      mCyc++;
      if (regWe) begin
        if (!regAddr) begin
          mSysReq = int'(regWdata[1:0]);
          mOutReq = int'(regWdata[3:2]);
        end else begin
          mSysLow = regWdata[0]; mHsExt = regWdata[1]; mLsX = regWdata[2];
        end
      end
    end
  end

  // tick driver
  always @(negedge clk) begin
    tickCyc++;
    xtalTick <= xtalOn && (tickCyc % 5 == 0);
    extTick  <= extOn && (tickCyc % 3 == 1);
  end

  // scoreboard: push expected, then pop and compare
  always @(negedge clk) begin
    #1;
    if (monOn) sbQ.push_back(calc());
  end

  task automatic cmp1(string name, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", curReq, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (monOn && sbQ.size() > 0) begin
      expect_t e;
      e = sbQ.pop_front();
      cmp1("hsEn", hsEn, e.hs);
      cmp1("lsEn", lsEn, e.ls);
      cmp1("ls2En", ls2En, e.ls2);
      cmp1("sysEn", sysEn, e.sys);
      cmp1("outEn", outEn, e.out);
      cmp1("sysOnLow", sysOnLow, e.onLow);
    end
  end

  task automatic writeReg(logic a, logic [3:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readCheck(logic a, logic [3:0] exp, string tag);
    @(negedge clk);
    regAddr = a;
    #3;
    compared++;
    if (regRdata !== exp) begin
      mismatched++;
      $display("FAIL %s regRdata[%0d]: actual %h expected %h", tag, a, regRdata, exp);
    end
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monOn = 1'b1;
    // R1: reset default divide-by-8 on the RC source
    curReq = "R1";
    runCycles(40);
    readCheck(1'b0, 4'hF, "R9");
    readCheck(1'b1, 4'h0, "R9");
    // R2 and R3: each system code, output divider at a different ratio
    curReq = "R2";
    writeReg(1'b0, 4'b0100);
    runCycles(20);
    writeReg(1'b0, 4'b0001);
    runCycles(20);
    curReq = "R3";
    writeReg(1'b0, 4'b1110);
    runCycles(30);
    // R4: shorten from /4 to /1 and widen back to /8 in mid-period
    curReq = "R4";
    runCycles(1);
    writeReg(1'b0, 4'b0000);
    runCycles(10);
    writeReg(1'b0, 4'b0011);
    runCycles(3);
    writeReg(1'b0, 4'b1111);
    runCycles(30);
    // R5: RC low-speed pair observed over several periods
    curReq = "R5";
    runCycles(50);
    // R6: move the low-speed pair to the crystal
    curReq = "R6";
    xtalOn = 1'b1;
    runCycles(7);
    writeReg(1'b1, 4'b0100);
    runCycles(80);
    // R7: system clock on low-speed, then back to divided high-speed
    curReq = "R7";
    writeReg(1'b1, 4'b0101);
    runCycles(60);
    writeReg(1'b0, 4'b0110);
    writeReg(1'b1, 4'b0100);
    runCycles(60);
    // R8: external high-speed source
    curReq = "R8";
    extOn = 1'b1;
    writeReg(1'b1, 4'b0110);
    runCycles(80);
    writeReg(1'b0, 4'b0001);
    runCycles(40);
    // R9: field layout, unused bit of register 1 reads zero
    curReq = "R9";
    writeReg(1'b1, 4'b1010);
    readCheck(1'b1, 4'b0010, "R9");
    writeReg(1'b0, 4'b1001);
    readCheck(1'b0, 4'b1001, "R9");
    runCycles(20);
    // R6 return: back to RC low-speed at a crystal boundary
    curReq = "R6";
    writeReg(1'b1, 4'b0000);
    runCycles(60);
    monOn = 1'b0;
    runCycles(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule